// File: doc/BRIEF.md
# Delayed interrupt flag controller

This block keeps the interrupt request state for a small processor core with five request sources: vertical blank, display status, timer, and two external sources. It holds a five-bit flag register, an eight-bit enable register and a five-bit staging register. A request either sets its flag bit in the cycle it arrives, or waits in the staging register until the next step of the unit that raised it.

The video sources (vertical blank and display status) go straight to the flags in the default mode. In the alternate mode they go to the staging register. Timer requests are always staged. Staged video bits move into the flags when the next video step starts, and the staged timer bit moves when the next timer step starts. The display status source fires only when its combined line rises between two video steps. Staged bits are visible when the flag register is read, and any write to the flag register discards them.

The core sees a pending set and a wake strobe. Staged bits count as pending only while the core is running. While it is halted, only committed flags count. So a halted core wakes one step later than a running core would notice the same request.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flags, staged bits, enable register and previous status line are all zero. A flag read then returns 0xE0 and an enable read returns 0x00.
- R2: With regSel=0, rdData returns 1 in bits 7..5 and the OR of flags and staged bits in bits 4..0. With regSel=1 it returns the enable register.
- R3: A write with regSel=0 stores wrData[4:0] as the flags and clears every staged bit. This wins over any commit or new request in the same cycle.
- R4: A write with regSel=1 stores all eight bits of wrData in the enable register and leaves the flags and staged bits alone.
- R5: Bit positions are vertical blank = bit 0, status = bit 1, timer = bit 2, extReq[0] = bit 3, extReq[1] = bit 4. With altMode=0, vblankReq in a vidStep cycle sets flag bit 0 at that clock edge. vblankReq without vidStep is ignored.
- R6: With altMode=1, video requests set staging bits 0/1 instead. Each vidStep moves staged bits 0/1 into the flags before that step's new requests are staged.
- R7: timerReq in a timStep cycle sets staged bit 2. Only the next timStep moves it into flag bit 2; a vidStep does not.
- R8: A status request is raised only in a vidStep cycle whose statLine is 1 after a statLine of 0 at the previous vidStep (0 after reset).
- R9: extReq bits set flag bits 3 and 4 directly in any cycle.
- R10: pending = enable[4:0] AND flags, ORed with enable[4:0] AND staged when halted=0. wake is 1 exactly when pending is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| altMode | input | 1 | 1 routes video requests through staging |
| vidStep | input | 1 | Video step strobe; commits staged bits 0/1 and qualifies video requests |
| vblankReq | input | 1 | Vertical blank request, taken only with vidStep |
| statLine | input | 1 | Combined display status interrupt line |
| timStep | input | 1 | Timer step strobe; commits staged bit 2 and qualifies timerReq |
| timerReq | input | 1 | Timer overflow request |
| extReq | input | 2 | Direct requests for flag bits 3 and 4 |
| regSel | input | 1 | 0 selects the flag register, 1 the enable register |
| regWr | input | 1 | Write strobe for the selected register |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected register |
| halted | input | 1 | Core is halted |
| pending | output | 5 | Enabled pending interrupt set |
| wake | output | 1 | Any interrupt pending; clears the halt |

## Verification
A bad staged bit shows on a flag read and on pending (when not halted) in the cycle right after the faulty edge. A bad commit shows only at the next step of the unit that owns the bit, so the bench reads back after every step and compares each cycle against a model. A wrong status edge memory shows as a missing or repeated status flag at the vidStep after the line changes. The halt gating shows as a pending difference between halted and running reads of the same state in the same cycle.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int SRC_N   = 5;
  localparam int DATA_W  = 8;
  localparam int VBL_BIT = 0;
  localparam int STS_BIT = 1;
  localparam int TMR_BIT = 2;
  localparam int EXT_LO  = 3;
  localparam int EXT_N   = SRC_N - EXT_LO;
  localparam int PAD_W   = DATA_W - SRC_N;

  typedef logic [SRC_N-1:0] srcVec_t;

  typedef struct packed {
    logic    wrFlag;
    logic    wrEnable;
    srcVec_t commitMask;
    srcVec_t directSet;
    srcVec_t stageSet;
  } ctlStrobes_t;
endpackage

// File: rtl/irq_flag_ctl.sv
module irq_flag_ctl
  import irq_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             altMode,
  input  logic             vidStep,
  input  logic             vblankReq,
  input  logic             statLine,
  input  logic             timStep,
  input  logic             timerReq,
  input  logic [EXT_N-1:0] extReq,
  input  logic             regSel,
  input  logic             regWr,
  output ctlStrobes_t      strobes
);
  logic    prevStat;
  logic    statRise;
  srcVec_t videoVec;

  // status line level remembered once per video step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevStat <= 1'b0;
    else if (vidStep) prevStat <= statLine;
  end

  assign statRise = vidStep & statLine & ~prevStat;

  always_comb begin
    videoVec = '0;
    videoVec[VBL_BIT] = vidStep & vblankReq;
    videoVec[STS_BIT] = statRise;
  end

  always_comb begin
    strobes = '0;
    strobes.wrFlag   = regWr & ~regSel;
    strobes.wrEnable = regWr & regSel;
    strobes.commitMask[VBL_BIT] = vidStep;
    strobes.commitMask[STS_BIT] = vidStep;
    strobes.commitMask[TMR_BIT] = timStep;
    if (altMode) strobes.stageSet  = videoVec;
    else         strobes.directSet = videoVec;
    strobes.stageSet[TMR_BIT] = timStep & timerReq;
    for (int i = 0; i < EXT_N; i++) begin
      strobes.directSet[EXT_LO+i] = extReq[i];
    end
  end
endmodule

// File: rtl/irq_flag_dp.sv
module irq_flag_dp
  import irq_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              regSel,
  input  logic              halted,
  output logic [DATA_W-1:0] rdData,
  output srcVec_t           pending,
  output srcVec_t           flagsQ,
  output srcVec_t           stagedQ
);
  logic [DATA_W-1:0] enableQ;
  srcVec_t           flagsNext;
  srcVec_t           stagedNext;
  srcVec_t           stagedSeen;

  always_comb begin
    if (strobes.wrFlag) begin
      flagsNext  = wrData[SRC_N-1:0];
      stagedNext = '0;
    end else begin
      flagsNext  = flagsQ | (stagedQ & strobes.commitMask) | strobes.directSet;
      stagedNext = (stagedQ & ~strobes.commitMask) | strobes.stageSet;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagsQ  <= '0;
      stagedQ <= '0;
      enableQ <= '0;
    end else begin
      flagsQ  <= flagsNext;
      stagedQ <= stagedNext;
      if (strobes.wrEnable) enableQ <= wrData;
    end
  end

  assign stagedSeen = halted ? '0 : stagedQ;
  assign pending    = enableQ[SRC_N-1:0] & (flagsQ | stagedSeen);
  assign rdData     = regSel ? enableQ : {{PAD_W{1'b1}}, flagsQ | stagedQ};
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              altMode,
  input  logic              vidStep,
  input  logic              vblankReq,
  input  logic              statLine,
  input  logic              timStep,
  input  logic              timerReq,
  input  logic [EXT_N-1:0]  extReq,
  input  logic              regSel,
  input  logic              regWr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              halted,
  output logic [SRC_N-1:0]  pending,
  output logic              wake
);
  ctlStrobes_t strobes;
  srcVec_t     flagsQ;
  srcVec_t     stagedQ;

  irq_flag_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .altMode(altMode), .vidStep(vidStep),
    .vblankReq(vblankReq), .statLine(statLine), .timStep(timStep),
    .timerReq(timerReq), .extReq(extReq), .regSel(regSel), .regWr(regWr),
    .strobes(strobes)
  );

  irq_flag_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrData(wrData),
    .regSel(regSel), .halted(halted), .rdData(rdData), .pending(pending),
    .flagsQ(flagsQ), .stagedQ(stagedQ)
  );

  assign wake = |pending;
endmodule

// File: rtl/irq_flag_chk.sv
module irq_flag_chk
  import irq_flag_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              altMode,
  input logic              vidStep,
  input logic              vblankReq,
  input logic              timStep,
  input logic              timerReq,
  input logic              regSel,
  input logic              regWr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              halted,
  input logic [SRC_N-1:0]  pending,
  input logic [SRC_N-1:0]  flagsQ,
  input logic [SRC_N-1:0]  stagedQ
);
  logic flagWr;
  assign flagWr = regWr & ~regSel;

  assert_flag_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flagWr |=> (stagedQ == '0) && (flagsQ == $past(wrData[SRC_N-1:0])));

  assert_direct_vblank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!altMode && vidStep && vblankReq && !flagWr) |=> flagsQ[VBL_BIT]);

  assert_staged_vblank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (altMode && vidStep && vblankReq && !flagWr) |=> stagedQ[VBL_BIT]);

  assert_timer_staged_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (timStep && timerReq && !flagWr) |=> stagedQ[TMR_BIT]);

  assert_pad_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !regSel |-> (rdData[DATA_W-1:SRC_N] == '1));

  assert_pending_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pending & ~(flagsQ | stagedQ)) == '0);

  assert_halt_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> ((pending & ~flagsQ) == '0));
endmodule

bind irq_flag_ctrl irq_flag_chk u_chk (
  .clk(clk), .rst_n(rst_n), .altMode(altMode), .vidStep(vidStep),
  .vblankReq(vblankReq), .timStep(timStep), .timerReq(timerReq),
  .regSel(regSel), .regWr(regWr), .wrData(wrData), .rdData(rdData),
  .halted(halted), .pending(pending), .flagsQ(flagsQ), .stagedQ(stagedQ)
);

// File: tb/tb_irq_flag_ctrl.sv
`timescale 1ns/1ps
module tb_irq_flag_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic altMode = 0, vidStep = 0, vblankReq = 0, statLine = 0;
  logic timStep = 0, timerReq = 0, regSel = 0, regWr = 0, halted = 0;
  logic [1:0] extReq = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [4:0] pending;
  logic wake;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  logic [4:0] mF = '0, mS = '0;
  logic [7:0] mIe = '0;
  logic mPrev = 1'b0;

  always #4 clk = ~clk;

  irq_flag_ctrl dut (
    .clk(clk), .rst_n(rst_n), .altMode(altMode), .vidStep(vidStep),
    .vblankReq(vblankReq), .statLine(statLine), .timStep(timStep),
    .timerReq(timerReq), .extReq(extReq), .regSel(regSel), .regWr(regWr),
    .wrData(wrData), .rdData(rdData), .halted(halted), .pending(pending),
    .wake(wake)
  );

  // next-state model from the requirements
  task automatic modelStep();
    logic [4:0] cm, vr, dir, stg;
    logic rise;
    rise = vidStep & statLine & ~mPrev;
    cm   = {2'b00, timStep, vidStep, vidStep};
    vr   = vidStep ? {3'b000, rise, vblankReq} : 5'b0;
    dir  = {extReq, 1'b0, altMode ? 2'b00 : vr[1:0]};
    stg  = {2'b00, timStep & timerReq, altMode ? vr[1:0] : 2'b00};
    if (regWr && !regSel) begin
      mF = wrData[4:0];
      mS = '0;
    end else begin
      mF = mF | (mS & cm) | dir;
      mS = (mS & ~cm) | stg;
    end
    if (regWr && regSel) mIe = wrData;
    if (vidStep) mPrev = statLine;
  endtask

  function automatic logic [7:0] expRd(logic sel);
    return sel ? mIe : {3'b111, mF | mS};
  endfunction

  function automatic logic [4:0] expPend(logic h);
    return mIe[4:0] & (mF | (h ? 5'b0 : mS));
  endfunction

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  task automatic idle();
    vidStep = 0; vblankReq = 0; timStep = 0; timerReq = 0;
    extReq = '0; regWr = 0;
  endtask

  task automatic rdCheck(string tag, logic sel, logic h, logic [7:0] eRd, logic [4:0] ePend);
    idle();
    regSel = sel; halted = h;
    #1;
    check(tag, "rdData", rdData, eRd);
    check(tag, "pending", {3'b0, pending}, {3'b0, ePend});
    check(tag, "wake", {7'b0, wake}, {7'b0, |ePend});
  endtask

  task automatic wrReg(logic sel, logic [7:0] d);
    idle();
    regSel = sel; regWr = 1; wrData = d;
    tick();
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    rdCheck("R1", 0, 0, 8'hE0, 5'h00);
    rdCheck("R1", 1, 0, 8'h00, 5'h00);

    wrReg(1, 8'h1F);
    rdCheck("R4", 1, 0, 8'h1F, 5'h00);
    rdCheck("R4", 0, 0, 8'hE0, 5'h00);

    idle(); altMode = 0; vblankReq = 1; tick();
    rdCheck("R5", 0, 0, 8'hE0, 5'h00);
    vidStep = 1; vblankReq = 1; tick();
    rdCheck("R5", 0, 0, 8'hE1, 5'h01);

    idle(); extReq = 2'b10; tick();
    rdCheck("R9", 0, 0, 8'hF1, 5'h11);

    wrReg(0, 8'h40);
    rdCheck("R3", 0, 0, 8'hE0, 5'h00);

    altMode = 1; statLine = 1; vidStep = 1; tick();
    rdCheck("R6", 0, 0, 8'hE2, 5'h02);
    rdCheck("R10", 0, 1, 8'hE2, 5'h00);
    vidStep = 1; tick();
    rdCheck("R6", 0, 1, 8'hE2, 5'h02);

    wrReg(0, 8'h00);
    vidStep = 1; tick();
    rdCheck("R8", 0, 0, 8'hE0, 5'h00);
    statLine = 0; vidStep = 1; tick();
    statLine = 1; vidStep = 1; tick();
    rdCheck("R8", 0, 0, 8'hE2, 5'h02);

    wrReg(0, 8'h00);
    rdCheck("R3", 0, 0, 8'hE0, 5'h00);

    timStep = 1; timerReq = 1; tick();
    rdCheck("R7", 0, 1, 8'hE4, 5'h00);
    vidStep = 1; tick();
    rdCheck("R7", 0, 1, 8'hE4, 5'h00);
    timStep = 1; tick();
    rdCheck("R7", 0, 1, 8'hE4, 5'h04);

    wrReg(0, 8'h00);
    timStep = 1; timerReq = 1; tick();
    idle(); timStep = 1; regSel = 0; regWr = 1; wrData = 8'h08; tick();
    rdCheck("R3", 0, 0, 8'hE8, 5'h08);

    wrReg(1, 8'h04);
    rdCheck("R10", 0, 0, 8'hE8, 5'h00);
    rdCheck("R4", 1, 0, 8'h04, 5'h00);

    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      vidStep   = ($urandom % 4) == 0;
      vblankReq = $urandom % 2;
      statLine  = (($urandom % 3) == 0) ? ~statLine : statLine;
      timStep   = ($urandom % 8) == 0;
      timerReq  = $urandom % 2;
      extReq    = (($urandom % 16) == 0) ? 2'($urandom) : 2'b00;
      regSel    = $urandom % 2;
      regWr     = ($urandom % 12) == 0;
      wrData    = 8'($urandom);
      halted    = $urandom % 2;
      if (($urandom % 64) == 0) altMode = ~altMode;
      #1;
      check("R2", "rdData", rdData, expRd(regSel));
      check("R10", "pending", {3'b0, pending}, {3'b0, expPend(halted)});
      check("R10", "wake", {7'b0, wake}, {7'b0, |expPend(halted)});
      tick();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule